// File: doc/BRIEF.md
# Sprite Pixel Sequencer

This block turns one trigger into a short burst of pixel addresses for a small ball of fixed shape. A framebuffer writer further down the chip gives it a top-left anchor (a 9-bit column and an 8-bit row) and raises the trigger. The sequencer captures the anchor and walks its list of pixel offsets, one pixel per clock. In each cycle it presents a screen coordinate together with a valid strobe. On the final pixel it raises a one-cycle completion flag.

The trigger is level-based with a re-arm rule. Once a ball has been emitted, the trigger must be seen low before another ball can start, so a held trigger produces exactly one ball. Offsets are added to the captured anchor modulo the coordinate width, and no clipping is done. The shape is chosen by a parameter: a 5-pixel plus (the default) or a 4-pixel 2x2 block.

Top module: `sprite_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in idle. In the cycle after `rst` is sampled high, `pix_valid` and `pix_last` are both low, even if a ball was being emitted.
- R2: While idle with `go` low, `pix_valid` stays low. When `go` is sampled high at a clock edge in idle, the first pixel appears in the cycle that follows that edge.
- R3: With the default plus shape, pixels come out in this order as (column, row) offsets from the anchor: (1,0), (0,1), (1,1), (2,1), (1,2). Each pixel has `pix_valid` high and `pix_x`/`pix_y` equal to the anchor plus the offset.
- R4: A ball is exactly 5 consecutive cycles of `pix_valid` high (4 for the block shape).
- R5: `pix_last` is high for exactly one cycle, and that cycle is the one carrying the last pixel.
- R6: If `go` is still high after a ball completes, no new pixel is emitted until `go` has been sampled low and then high again.
- R7: The anchor is captured at the start edge. Changes on `anchor_x`/`anchor_y` during emission do not alter the ball.
- R8: `pix_valid` is low in every cycle that carries no pixel, including the wait for `go` to fall.
- R9: Coordinates wrap at their width. With an anchor of (510,255), offset (2,1) gives column 0, and offset (1,2) gives row 1.
- R10: Dropping `go` during emission does not abort the ball. All pixels are still emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Level trigger; starts a ball from idle |
| anchor_x | input | 9 | Leftmost column of the ball |
| anchor_y | input | 8 | Topmost row of the ball |
| pix_valid | output | 1 | Current coordinate is a pixel to draw |
| pix_x | output | 9 | Pixel column |
| pix_y | output | 8 | Pixel row |
| pix_last | output | 1 | Final pixel of the ball |

## Verification
The hardest situation to reach is the re-arm wait. To get there, the trigger must stay high through the whole ball and past its last pixel, then be released, then raised again. The stimulus holds `go` across the completion for several cycles and checks for silence. It then releases `go` and starts a fresh ball. The anchor inputs are scrambled right after each start to expose any anchor path that is not latched. A reset is also asserted in the middle of a ball.

// File: rtl/sprite_seq_pkg.sv
package sprite_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EMIT  = 2'd1,
      ST_REARM = 2'd2
   } seq_state_e;

   localparam int SHAPE_PLUS  = 0;
   localparam int SHAPE_BLOCK = 1;

   function automatic int shape_len(input int sel);
      return (sel == SHAPE_BLOCK) ? 4 : 5;
   endfunction

   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sprite_shape_rom.sv
module sprite_shape_rom #(
   parameter int SHAPE = 0,
   parameter int IW    = 3,
   parameter int OW    = 2
) (
   input  logic [IW-1:0] idx,
   output logic [OW-1:0] dx,
   output logic [OW-1:0] dy
);
   import sprite_seq_pkg::*;

   initial begin
      assert (OW >= 2) else $error("offset width too small");
      assert (SHAPE == SHAPE_PLUS || SHAPE == SHAPE_BLOCK) else $error("unknown shape");
   end

   generate
      if (SHAPE == SHAPE_PLUS) begin : g_plus
         always_comb begin
            case (idx)
               IW'(0):  begin dx = OW'(1); dy = OW'(0); end
               IW'(1):  begin dx = OW'(0); dy = OW'(1); end
               IW'(2):  begin dx = OW'(1); dy = OW'(1); end
               IW'(3):  begin dx = OW'(2); dy = OW'(1); end
               IW'(4):  begin dx = OW'(1); dy = OW'(2); end
               default: begin dx = '0;     dy = '0;     end
            endcase
         end
      end else begin : g_block
         always_comb begin
            dx = OW'(idx[0]);
            dy = OW'(idx[1]);
         end
      end
   endgenerate

endmodule

// File: rtl/sprite_anchor_add.sv
module sprite_anchor_add #(
   parameter int XW = 9,
   parameter int YW = 8,
   parameter int OW = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [XW-1:0] ax_in,
   input  logic [YW-1:0] ay_in,
   input  logic [OW-1:0] dx,
   input  logic [OW-1:0] dy,
   output logic [XW-1:0] px,
   output logic [YW-1:0] py
);
   logic [XW-1:0] anc_x;
   logic [YW-1:0] anc_y;

   initial begin
      assert (XW > OW && YW > OW) else $error("coordinate width below offset width");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         anc_x <= '0;
         anc_y <= '0;
      end else if (load) begin
         anc_x <= ax_in;
         anc_y <= ay_in;
      end
   end

   // modulo-width add, no clipping (R9)
   always_comb begin
      px = anc_x + XW'(dx);
      py = anc_y + YW'(dy);
   end

   // R7: anchor only moves on a load
   a_r7_anchor_hold: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(anc_x) && $stable(anc_y)));

endmodule

// File: rtl/sprite_seq_ctrl.sv
module sprite_seq_ctrl #(
   parameter int NPIX = 5,
   parameter int IW   = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   output logic          load,
   output logic          emit,
   output logic          last,
   output logic [IW-1:0] idx
);
   import sprite_seq_pkg::*;

   localparam logic [IW-1:0] LAST_IDX = IW'(NPIX - 1);

   seq_state_e state, state_nx;
   logic [IW-1:0] idx_nx;

   initial begin
      assert (NPIX >= 4) else $error("shape needs at least four pixels");
      assert ((1 << IW) >= NPIX) else $error("index too narrow");
   end

   always_comb begin
      state_nx = state;
      idx_nx   = idx;
      case (state)
         ST_IDLE: begin
            if (go) begin
               state_nx = ST_EMIT;
               idx_nx   = '0;
            end
         end
         ST_EMIT: begin
            if (idx == LAST_IDX) begin
               state_nx = ST_REARM;
               idx_nx   = '0;
            end else begin
               idx_nx = idx + IW'(1);
            end
         end
         ST_REARM: begin
            if (!go) state_nx = ST_IDLE;
         end
         default: begin
            state_nx = ST_IDLE;
            idx_nx   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         state <= state_nx;
         idx   <= idx_nx;
      end
   end

   assign load = (state == ST_IDLE) && go;
   assign emit = (state == ST_EMIT);
   assign last = emit && (idx == LAST_IDX);

   // R2: idle without a trigger stays quiet
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && !go) |=> !emit);
   // R2: trigger in idle starts emission next cycle
   a_r2_start_next: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && go) |=> (emit && idx == '0));
   // R6: held trigger in re-arm wait never restarts
   a_r6_hold_rearm: assert property (@(posedge clk) disable iff (rst)
      (state == ST_REARM && go) |=> !emit);
   // R10: emission runs to the end regardless of go
   a_r10_no_abort: assert property (@(posedge clk) disable iff (rst)
      (emit && !last) |=> (emit && idx == $past(idx) + IW'(1)));
   // R4: index stays inside the shape
   a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
      emit |-> (idx <= LAST_IDX));

endmodule

// File: rtl/sprite_seq.sv
module sprite_seq #(
   parameter int XW    = 9,
   parameter int YW    = 8,
   parameter int SHAPE = 0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          go,
   input  logic [XW-1:0] anchor_x,
   input  logic [YW-1:0] anchor_y,
   output logic          pix_valid,
   output logic [XW-1:0] pix_x,
   output logic [YW-1:0] pix_y,
   output logic          pix_last
);
   import sprite_seq_pkg::*;

   localparam int NPIX = shape_len(SHAPE);
   localparam int IW   = idx_width(NPIX);
   localparam int OW   = 2;

   logic          load, emit, last;
   logic [IW-1:0] idx;
   logic [OW-1:0] dx, dy;

   initial begin
      assert (XW >= 4 && YW >= 4) else $error("coordinate widths too small");
   end

   sprite_seq_ctrl #(.NPIX(NPIX), .IW(IW)) ctrl_i (
      .clk (clk), .rst (rst), .go (go),
      .load(load), .emit(emit), .last(last), .idx(idx)
   );

   sprite_shape_rom #(.SHAPE(SHAPE), .IW(IW), .OW(OW)) rom_i (
      .idx(idx), .dx(dx), .dy(dy)
   );

   sprite_anchor_add #(.XW(XW), .YW(YW), .OW(OW)) add_i (
      .clk(clk), .rst(rst), .load(load),
      .ax_in(anchor_x), .ay_in(anchor_y),
      .dx(dx), .dy(dy), .px(pix_x), .py(pix_y)
   );

   assign pix_valid = emit;
   assign pix_last  = last;

   // R1: reset clears the strobes
   a_r1_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!pix_valid && !pix_last));
   // R5: completion flag only with a pixel
   a_r5_last_with_pixel: assert property (@(posedge clk) disable iff (rst)
      pix_last |-> pix_valid);
   // R5: completion flag lasts one cycle
   a_r5_last_single: assert property (@(posedge clk) disable iff (rst)
      pix_last |=> !pix_last);
   // R8: silence right after the last pixel
   a_r8_quiet_after: assert property (@(posedge clk) disable iff (rst)
      pix_last |=> !pix_valid);

endmodule

// File: tb/sprite_seq_tb_top.sv
module sprite_seq_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       go  = 1'b0;
   logic [8:0] anchor_x = '0;
   logic [7:0] anchor_y = '0;
   logic       pix_valid, pix_last;
   logic [8:0] pix_x;
   logic [7:0] pix_y;

   int checks = 0;
   int bad    = 0;
   bit ended  = 1'b0;

   localparam int NV = 5;
   localparam int VX [NV] = '{100, 150, 0, 510, 300};
   localparam int VY [NV] = '{200, 20, 0, 255, 128};
   localparam int OX [5]  = '{1, 0, 1, 2, 1};
   localparam int OY [5]  = '{0, 1, 1, 1, 2};

   always #5 clk = ~clk;

   sprite_seq dut_i (
      .clk(clk), .rst(rst), .go(go),
      .anchor_x(anchor_x), .anchor_y(anchor_y),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_last(pix_last)
   );

   task automatic chkv(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   // one ball; anchors scrambled after start (R7), go dropped early unless hold (R10)
   task automatic draw_ball(input int ax, input int ay, input bit hold);
      @(negedge clk);
      anchor_x = 9'(ax);
      anchor_y = 8'(ay);
      go = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chkv("R3 valid", int'(pix_valid), 1);
         chkv("R3/R7/R9 x", int'(pix_x), (ax + OX[i]) % 512);
         chkv("R3/R7/R9 y", int'(pix_y), (ay + OY[i]) % 256);
         chkv("R5 last", int'(pix_last), (i == 4) ? 1 : 0);
         if (i == 0) begin
            anchor_x = 9'(ax + 77);
            anchor_y = 8'(ay + 33);
            if (!hold) go = 1'b0;
         end
      end
      @(negedge clk);
      chkv("R4/R8 quiet after ball", int'(pix_valid), 0);
      chkv("R5 last one cycle", int'(pix_last), 0);
      if (hold) begin
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chkv("R6 held go no redraw", int'(pix_valid), 0);
         end
         go = 1'b0;
      end
      repeat (2) @(negedge clk);
      chkv("R8 idle quiet", int'(pix_valid), 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chkv("R1 reset valid", int'(pix_valid), 0);
      chkv("R1 reset last", int'(pix_last), 0);
      rst = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chkv("R2 idle without go", int'(pix_valid), 0);
      end
      // vector table walk
      for (int v = 0; v < NV; v++) draw_ball(VX[v], VY[v], 1'b0);
      // R6: held trigger across completion, then re-armed
      draw_ball(40, 60, 1'b1);
      draw_ball(41, 61, 1'b0);
      // R1: reset during emission
      @(negedge clk);
      anchor_x = 9'd20; anchor_y = 8'd30; go = 1'b1;
      repeat (2) @(negedge clk);
      chkv("R1 mid-ball valid before reset", int'(pix_valid), 1);
      rst = 1'b1; go = 1'b0;
      @(negedge clk);
      chkv("R1 valid after mid reset", int'(pix_valid), 0);
      chkv("R1 last after mid reset", int'(pix_last), 0);
      rst = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chkv("R2 idle after reset", int'(pix_valid), 0);
      end
      draw_ball(7, 9, 1'b0);
      finish_run();
   end

   initial begin
      #2000000;
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

endmodule